// File: doc/BRIEF.md
# Cache Lock Decision Unit

This unit sits beside an instruction-cache controller. On every miss fill it tells the controller whether the fetched block belongs to the fixed set of blocks picked for locking. The input is a block address: the fetch address with the byte-within-line bits removed. A 16-byte line holds four 4-byte instructions, so a 16-bit bus leaves 12 address bits and a 32-bit bus leaves 28. A set bit on the output means the controller loads and locks the line. A clear bit means it must not store the line at all.

The set of selected blocks is fixed when the design is built and comes in as a parameter list with a count. Each entry becomes one minterm. A minterm cuts the address into slices no wider than a lookup input width. It compares each slice with a constant and ANDs the slice results. When two entries hold the same slice value at the same position, they share one comparator.

The hit vector is reduced in two stages. Each chunk of hits is added to an all-ones value of its own width, and the carry-out is registered. The registered carries are ORed in groups of six. A second add-to-all-ones chain then produces the answer. A force input makes the answer 1 for every address, so the cache acts as a normal unlocked cache, for example while non-real-time tasks run.

Top module: `lock_state_gen`

## Requirements
- R1: A request sampled with `blk_valid_i` high produces `lock_valid_o` high exactly LATENCY clock edges later (default 2). A new request can be accepted on every cycle.
- R2: `lock_o` is 0 in every cycle in which `lock_valid_o` is 0.
- R3: With force low, a valid request returns `lock_o` = 1 when its 12-bit block address equals an entry of the selected list, and 0 when it equals none.
- R4: A match returns 1 no matter which chunk or which group of six chunk carries its entry falls in, including a partially filled last chunk or group.
- R5: A list that holds the same address twice gives the same result for every address as a list that holds it once.
- R6: A valid request with `force_lock_i` high returns `lock_o` = 1 for any address.
- R7: When the list count is zero, every valid request returns 0 unless force is high.
- R8: While `rst_ni` is low, `lock_valid_o` and `lock_o` are 0, and requests in flight when reset is asserted are dropped.
- R9: Entries that share a slice value at one position and differ at another are still told apart exactly. This covers addresses that differ from an entry in only one slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | Request strobe for this cycle |
| blk_addr_i | input | ADDR_W | Block address (fetch address without line offset) |
| force_lock_i | input | 1 | Force the answer of this request to 1 |
| lock_valid_o | output | 1 | Answer valid, LATENCY cycles after the request |
| lock_o | output | 1 | 1 = load and lock the block, 0 = do not store it |

## Verification
A request driven at one falling edge is captured by the first stage at the next rising edge. Its answer leaves the last output register one rising edge later for the default depth of two, or later by one edge for each extra stage. The bench keeps a shift line of expected results as deep as each instance's latency. At every falling edge it compares the outputs with the entry that has aged exactly that many steps, and only then drives the next request. Back-to-back sweeps over all 4096 addresses, with valid patterns that have gaps and with force set, check two instances at once: a 14-entry list and a zero-length list with latency 3.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/lsg_carry_chunk.sv
module lsg_carry_chunk #(
    parameter int WIDTH = 48
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             carry_o
);
    logic [WIDTH-1:0] sum_unused;

    // Adding an all-ones constant overflows exactly when any bit is set.
    assign {carry_o, sum_unused} = {1'b0, bits_i} + {1'b0, {WIDTH{1'b1}}};

    always_comb begin
        a_r4_carry_any: assert (carry_o == (|bits_i));
    end

endmodule

// File: rtl/lsg_minterm_array.sv
module lsg_minterm_array
    import lsg_pkg::*;
#(
    parameter int                        ADDR_W  = 12,
    parameter int                        SLICE_W = 6,
    parameter int                        N_ENT   = 8,
    parameter logic [N_ENT*ADDR_W-1:0]   ENTRIES = '0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [N_ENT-1:0]  hit_o
);
    localparam int N_SLC = ceil_div(ADDR_W, SLICE_W);
    localparam int PAD_W = N_SLC * SLICE_W;

    function automatic logic [SLICE_W-1:0] slice_of(input int ent, input int slc);
        logic [PAD_W-1:0] wide;
        wide = PAD_W'(ENTRIES[ent*ADDR_W +: ADDR_W]);
        return wide[slc*SLICE_W +: SLICE_W];
    endfunction

    // Lowest entry index that holds the same slice pattern at this position.
    function automatic int owner_of(input int ent, input int slc);
        for (int j = 0; j < ent; j++) begin
            if (slice_of(j, slc) == slice_of(ent, slc)) return j;
        end
        return ent;
    endfunction

    logic [PAD_W-1:0] addr_pad;
    logic [N_ENT-1:0] cmp_eq [N_SLC];

    assign addr_pad = PAD_W'(addr_i);

    // First level: one comparator per distinct (position, pattern) pair.
    for (genvar s = 0; s < N_SLC; s++) begin : g_slc
        for (genvar e = 0; e < N_ENT; e++) begin : g_ent
            if (owner_of(e, s) == e) begin : g_cmp
                assign cmp_eq[s][e] = (addr_pad[s*SLICE_W +: SLICE_W] == slice_of(e, s));
            end else begin : g_none
                assign cmp_eq[s][e] = 1'b0;
            end
        end
    end

    // Second level: AND of the slice results, reading shared comparators.
    for (genvar e = 0; e < N_ENT; e++) begin : g_term
        logic [N_SLC-1:0] part;
        for (genvar s = 0; s < N_SLC; s++) begin : g_pick
            assign part[s] = cmp_eq[s][owner_of(e, s)];
        end
        assign hit_o[e] = &part;
    end

endmodule

// File: rtl/lock_state_gen.sv
module lock_state_gen
    import lsg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int SLICE_W  = 6,
    parameter int N_SEL    = 8,
    parameter logic [((N_SEL > 0) ? N_SEL : 1)*ADDR_W-1:0] SEL_FLAT =
        {12'hC40, 12'h3A7, 12'h123, 12'h000, 12'h7FF, 12'h050, 12'h3A0, 12'h3A7},
    parameter int CHUNK_W  = 48,
    parameter int GROUP_W  = 6,
    parameter int LATENCY  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              blk_valid_i,
    input  logic [ADDR_W-1:0] blk_addr_i,
    input  logic              force_lock_i,
    output logic              lock_valid_o,
    output logic              lock_o
);
    localparam int N_ENT   = (N_SEL > 0) ? N_SEL : 1;
    localparam int N_CHUNK = ceil_div(N_ENT, CHUNK_W);
    localparam int HIT_PAD = N_CHUNK * CHUNK_W;
    localparam int N_GRP   = ceil_div(N_CHUNK, GROUP_W);
    localparam int GRP_PAD = N_GRP * GROUP_W;
    localparam int TAIL    = LATENCY - 1;

    typedef struct packed {
        logic               s1_valid;
        logic               s1_force;
        logic [N_CHUNK-1:0] s1_carry;
        logic [TAIL-1:0]    p_valid;
        logic [TAIL-1:0]    p_lock;
    } state_t;

    state_t q, d;

    logic [N_ENT-1:0]   hits_raw;
    logic [N_ENT-1:0]   hits;
    logic [HIT_PAD-1:0] hit_pad;
    logic [N_CHUNK-1:0] chunk_carry;
    logic [GRP_PAD-1:0] carry_pad;
    logic [N_GRP-1:0]   grp_or;
    logic               any_hit;

    lsg_minterm_array #(
        .ADDR_W (ADDR_W),
        .SLICE_W(SLICE_W),
        .N_ENT  (N_ENT),
        .ENTRIES(SEL_FLAT)
    ) u_terms (
        .addr_i(blk_addr_i),
        .hit_o (hits_raw)
    );

    assign hits    = (N_SEL > 0) ? hits_raw : '0;
    assign hit_pad = HIT_PAD'(hits);

    // Stage one: carry reduction per chunk.
    for (genvar c = 0; c < N_CHUNK; c++) begin : g_chunk
        lsg_carry_chunk #(.WIDTH(CHUNK_W)) u_chunk (
            .bits_i (hit_pad[c*CHUNK_W +: CHUNK_W]),
            .carry_o(chunk_carry[c])
        );
    end

    // Stage two: OR of registered carries in groups, then one more chain.
    assign carry_pad = GRP_PAD'(q.s1_carry);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        assign grp_or[g] = |carry_pad[g*GROUP_W +: GROUP_W];
    end

    lsg_carry_chunk #(.WIDTH(N_GRP)) u_final (
        .bits_i (grp_or),
        .carry_o(any_hit)
    );

    always_comb begin
        d = q;
        d.s1_valid = blk_valid_i;
        d.s1_force = blk_valid_i & force_lock_i;
        d.s1_carry = blk_valid_i ? chunk_carry : '0;
        for (int k = TAIL - 1; k > 0; k--) begin
            d.p_valid[k] = q.p_valid[k-1];
            d.p_lock[k]  = q.p_lock[k-1];
        end
        d.p_valid[0] = q.s1_valid;
        d.p_lock[0]  = q.s1_valid & (q.s1_force | any_hit);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign lock_valid_o = q.p_valid[TAIL-1];
    assign lock_o       = q.p_lock[TAIL-1];

    // R2: no lock answer without a valid flag.
    a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_valid_o |-> !lock_o);

    // R4: a registered chunk carry must reach the next output stage.
    a_r4_chunk_to_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.s1_valid && (|q.s1_carry)) |=> q.p_lock[0]);

    for (genvar e = 0; e < N_SEL; e++) begin : g_chk
        // R3 / R9: a minterm only fires on its exact address.
        a_r3_hit_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hits[e] |-> (blk_addr_i == SEL_FLAT[e*ADDR_W +: ADDR_W]));
        for (genvar f = e + 1; f < N_SEL; f++) begin : g_dup
            if (SEL_FLAT[e*ADDR_W +: ADDR_W] == SEL_FLAT[f*ADDR_W +: ADDR_W]) begin : g_same
                // R5: duplicated entries fire together.
                a_r5_dup_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    hits[e] == hits[f]);
            end
        end
    end

endmodule

// File: tb/lock_state_gen_test.sv
`timescale 1ns/1ps
module lock_state_gen_test;

    localparam int AW = 12;
    localparam int NL = 14;
    localparam logic [NL*AW-1:0] LIST = {
        12'h03F, 12'hFC0, 12'h040, 12'h001, 12'h83F, 12'h7FF, 12'h7C0,
        12'hABC, 12'h041, 12'h081, 12'h042, 12'h041, 12'hFFF, 12'h000
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vld = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          frc = 1'b0;
    logic          u_valid, u_lock, m_valid, m_lock;

    int    tests = 0;
    int    fails = 0;
    string cur_tag = "R8";

    logic ev [2];
    logic el [2];
    logic mv [3];
    logic ml [3];

    always #10 clk = ~clk;

    lock_state_gen #(
        .ADDR_W(AW), .SLICE_W(6), .N_SEL(NL), .SEL_FLAT(LIST),
        .CHUNK_W(2), .GROUP_W(6), .LATENCY(2)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(vld), .blk_addr_i(addr),
        .force_lock_i(frc), .lock_valid_o(u_valid), .lock_o(u_lock)
    );

    // R7: empty list, deeper pipeline.
    lock_state_gen #(
        .ADDR_W(AW), .SLICE_W(6), .N_SEL(0), .SEL_FLAT('0),
        .CHUNK_W(48), .GROUP_W(6), .LATENCY(3)
    ) uut_empty (
        .clk_i(clk), .rst_ni(rst_n), .blk_valid_i(vld), .blk_addr_i(addr),
        .force_lock_i(frc), .lock_valid_o(m_valid), .lock_o(m_lock)
    );

    function automatic logic member(input logic [AW-1:0] a);
        for (int k = 0; k < NL; k++) begin
            if (LIST[k*AW +: AW] == a) return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic chk(input string what, input logic got, input logic exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", cur_tag, what, got, exp);
        end
    endtask

    task automatic clear_exp();
        for (int k = 0; k < 2; k++) begin ev[k] = 1'b0; el[k] = 1'b0; end
        for (int k = 0; k < 3; k++) begin mv[k] = 1'b0; ml[k] = 1'b0; end
    endtask

    // One request per falling edge; outputs checked against the entry of matching age.
    task automatic step(input logic v, input logic [AW-1:0] a, input logic f);
        @(negedge clk);
        chk("valid", u_valid, ev[1]);
        chk("lock", u_lock, el[1]);
        chk("empty valid", m_valid, mv[2]);
        chk("empty lock", m_lock, ml[2]);
        ev[1] = ev[0]; el[1] = el[0];
        mv[2] = mv[1]; ml[2] = ml[1];
        mv[1] = mv[0]; ml[1] = ml[0];
        ev[0] = v;
        el[0] = v && (f || member(a));
        mv[0] = v;
        ml[0] = v && f;
        vld  = v;
        addr = a;
        frc  = f;
    endtask

    initial begin
        #(20.0 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clear_exp();
        // R8: outputs quiet under reset.
        cur_tag = "R8";
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("reset valid", u_valid, 1'b0);
            chk("reset lock", u_lock, 1'b0);
            chk("reset empty valid", m_valid, 1'b0);
            chk("reset empty lock", m_lock, 1'b0);
        end
        rst_n = 1'b1;

        // R1 R3 R4 R5 R7 R9: full back-to-back sweep, force low.
        cur_tag = "R3";
        for (int a = 0; a < 4096; a++) step(1'b1, AW'(a), 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);

        // Every listed entry, including the last chunk and duplicates (R4, R5).
        cur_tag = "R4";
        for (int k = NL - 1; k >= 0; k--) step(1'b1, LIST[k*AW +: AW], 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);

        // R2 R1: gaps in the valid stream, addresses near entries (R9).
        cur_tag = "R2";
        for (int a = 0; a < 4096; a++) step(a[0] ^ a[3], AW'(a ^ 12'h040), 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);

        // R6: force high, gaps included.
        cur_tag = "R6";
        for (int a = 0; a < 4096; a++) step(a[2:0] != 3'd5, AW'(a), 1'b1);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);

        // R8: reset while requests are in flight.
        cur_tag = "R8";
        step(1'b1, 12'h041, 1'b0);
        step(1'b1, 12'hFFF, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        vld = 1'b0;
        #1;
        chk("flush valid", u_valid, 1'b0);
        chk("flush lock", u_lock, 1'b0);
        chk("flush empty valid", m_valid, 1'b0);
        chk("flush empty lock", m_lock, 1'b0);
        clear_exp();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) step(1'b0, '0, 1'b0);

        // R9: one-slice-off neighbours of a shared-slice pair.
        cur_tag = "R9";
        step(1'b1, 12'h041, 1'b0);
        step(1'b1, 12'h081, 1'b0);
        step(1'b1, 12'h0C1, 1'b0);
        step(1'b1, 12'h043, 1'b0);
        for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule